// File: doc/BRIEF.md
# Transparent Serial Receive Synchronizer

This block sits between a bit-serial unframed data line and the byte-wide logic that uses it. The receive side stays gated until synchronization is reached. Synchronization comes either from an in-line bit pattern of 4, 8 or 16 bits, matched against a programmable 16-bit pattern register, or from an external carrier-detect input. Once synchronized, every received bit is packed into bytes. The bytes are offered on a valid/ready output.

The transmit side takes bytes and shifts them out serially, one bit per transmit tick. It only runs once it has been released. In external mode, a clear-to-send input releases it. It can also be slaved to the receiver, so that it waits for receive synchronization. No sync pattern is ever inserted by the transmitter. Any pattern the far end needs is sent as ordinary data bytes.

For each external input, a static option selects pulse behaviour or level behaviour. In pulse behaviour, one assertion starts the channel and the channel stays latched. In level behaviour, the input must stay asserted for the whole transfer.

Top module: `serial_sync_gate`

## Requirements
- R1: The captured length code selects the sync source: 2'b00 external carrier-detect/clear-to-send, 2'b01 a 4-bit pattern, 2'b10 an 8-bit pattern, 2'b11 a 16-bit pattern. The pattern is the low N bits of the captured pattern register. It is compared with the last N received bits, where the newest bit is bit 0, so the first bit on the line is the most significant bit of the pattern.
- R2: In pattern mode, rx_synced rises in the cycle after the clock edge that captured the last pattern bit. The very next received bit is the first data bit. Pattern bits never appear in the data, and fewer than N received bits never match.
- R3: In external mode with cd_pulse=1, one cycle of cd high sets rx_synced. rx_synced then stays high after cd falls.
- R4: In external mode with cd_pulse=0, cd going low while synchronized clears rx_synced. The same edge raises sync_lost for exactly one cycle, discards the partial byte, and returns the receiver to hunting.
- R5: rx_en low clears rx_synced after the next edge and restarts the hunt. sync_len and sync_pat are captured only while rx_en is low. Changes made while rx_en is high have no effect.
- R6: Data bits are packed MSB first (the first bit received is bit 7). A completed byte is held on rx_byte with rx_byte_valid high, without change, until rx_byte_ready is seen.
- R7: If a byte completes while the previous byte has not been accepted, the new byte is dropped and rx_overrun is set. rx_overrun stays set until rx_en goes low.
- R8: In external mode the transmitter is released only by cts. With cts_pulse=0, cts must stay high, and dropping cts stops the transmitter and discards the byte it holds. With cts_pulse=1, one cts pulse while tx_en is high latches the release.
- R9: With tx_follow_rx=1, tx_byte_ready stays low until rx_synced is high.
- R10: An accepted tx_byte is shifted out MSB first, one bit per tx_tick, each bit marked by tx_bit_valid. Exactly the 8 data bits are sent, with nothing inserted. tx_byte_ready is high only when the transmitter is released and holds no bits.
- R11: In pattern mode, cts has no effect on the transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low clears sync and captures configuration |
| sync_len | input | 2 | Sync source / pattern length code |
| sync_pat | input | 16 | Sync pattern (low N bits used) |
| cd_pulse | input | 1 | 1: carrier detect latches; 0: must stay high |
| cd | input | 1 | Carrier detect |
| rx_bit_valid | input | 1 | Strobe: rx_bit carries a line bit |
| rx_bit | input | 1 | Received line bit |
| rx_byte | output | 8 | Received byte |
| rx_byte_valid | output | 1 | rx_byte holds an unaccepted byte |
| rx_byte_ready | input | 1 | Consumer accepts rx_byte |
| rx_overrun | output | 1 | Sticky: a byte was dropped |
| rx_synced | output | 1 | Receiver synchronized |
| sync_lost | output | 1 | One-cycle flag on carrier loss |
| tx_en | input | 1 | Transmitter enable |
| tx_follow_rx | input | 1 | Transmitter waits for receive sync |
| cts_pulse | input | 1 | 1: clear-to-send latches; 0: must stay high |
| cts | input | 1 | Clear-to-send |
| tx_byte | input | 8 | Byte to transmit |
| tx_byte_valid | input | 1 | tx_byte is offered |
| tx_byte_ready | output | 1 | Transmitter can take a byte |
| tx_tick | input | 1 | Transmit bit strobe |
| tx_bit | output | 1 | Transmitted line bit |
| tx_bit_valid | output | 1 | tx_bit is valid this cycle |

## Verification
The bench sends each pattern length behind noise. It checks that synchronization appears only after the final pattern bit. A design that was off by one bit, or that compared the wrong end of the pattern register, would then pull a pattern bit into the first data byte, and the byte scoreboard would catch it. It tests the 16-bit pattern in two ways: with 15 bits only, and after a disable/enable cycle. It also changes the pattern and length while the receiver is enabled, to show that configuration is captured only while disabled. It drops carrier mid-byte in level mode. A design that kept the partial bits would corrupt the next byte. It also holds ready low across two bytes, expecting the first byte to be kept and an overrun to be flagged. On the transmit side it checks each cts gating mode, the rule that pattern mode ignores cts, slaving to the receiver, and that a byte is discarded when cts falls, which a design that paused instead of stopping would later emit.

// File: rtl/serial_sync_gate.sv
module serial_sync_gate #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [1:0]        sync_len,
  input  logic [15:0]       sync_pat,
  input  logic              cd_pulse,
  input  logic              cd,
  input  logic              rx_bit_valid,
  input  logic              rx_bit,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_valid,
  input  logic              rx_byte_ready,
  output logic              rx_overrun,
  output logic              rx_synced,
  output logic              sync_lost,
  input  logic              tx_en,
  input  logic              tx_follow_rx,
  input  logic              cts_pulse,
  input  logic              cts,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_byte_valid,
  output logic              tx_byte_ready,
  input  logic              tx_tick,
  output logic              tx_bit,
  output logic              tx_bit_valid
);
  localparam int BC_W = $clog2(BYTE_W + 1);

  logic [1:0]        len_q;
  logic [15:0]       pat_q, hist_q;
  logic [4:0]        seen_q;
  logic              synced_q, lost_q, ovalid_q, ovr_q, cts_lat_q;
  logic [BYTE_W-1:0] acc_q, obyte_q, tsh_q;
  logic [BC_W-1:0]   acnt_q, tcnt_q;
  logic              tbit_q, tvalid_q;

  logic [15:0] mask;
  logic [4:0]  need;
  always_comb begin
    case (len_q)
      2'b01:   begin mask = 16'h000F; need = 5'd4;  end
      2'b10:   begin mask = 16'h00FF; need = 5'd8;  end
      2'b11:   begin mask = 16'hFFFF; need = 5'd16; end
      default: begin mask = 16'h0000; need = 5'd16; end
    endcase
  end

  wire        ext_mode   = (len_q == 2'b00);
  wire [15:0] hist_nxt   = {hist_q[14:0], rx_bit};
  wire [4:0]  seen_nxt   = (seen_q == 5'd16) ? seen_q : seen_q + 5'd1;
  wire        pat_hit    = !ext_mode && rx_bit_valid && (seen_nxt >= need) &&
                           (((hist_nxt ^ pat_q) & mask) == 16'h0000);
  wire        ext_hit    = ext_mode && cd;
  wire        level_drop = ext_mode && !cd_pulse && synced_q && !cd;
  wire        byte_done  = (acnt_q == BC_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= 2'b00;
      pat_q <= '0;
    end else if (!rx_en) begin
      len_q <= sync_len;
      pat_q <= sync_pat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      lost_q   <= 1'b0;
      hist_q   <= '0;
      seen_q   <= '0;
      acc_q    <= '0;
      acnt_q   <= '0;
      obyte_q  <= '0;
      ovalid_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else if (!rx_en) begin
      synced_q <= 1'b0;
      lost_q   <= 1'b0;
      hist_q   <= '0;
      seen_q   <= '0;
      acnt_q   <= '0;
      ovalid_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      lost_q <= 1'b0;
      if (ovalid_q && rx_byte_ready) ovalid_q <= 1'b0;
      if (!synced_q) begin
        if (rx_bit_valid && !ext_mode) begin
          hist_q <= hist_nxt;
          seen_q <= seen_nxt;
        end
        if (pat_hit || ext_hit) synced_q <= 1'b1;
      end else if (level_drop) begin
        synced_q <= 1'b0;
        lost_q   <= 1'b1;
        acnt_q   <= '0;
        hist_q   <= '0;
        seen_q   <= '0;
      end else if (rx_bit_valid) begin
        if (byte_done) begin
          acnt_q <= '0;
          if (!ovalid_q || rx_byte_ready) begin
            obyte_q  <= {acc_q[BYTE_W-2:0], rx_bit};
            ovalid_q <= 1'b1;
          end else begin
            ovr_q <= 1'b1;
          end
        end else begin
          acc_q  <= {acc_q[BYTE_W-2:0], rx_bit};
          acnt_q <= acnt_q + 1'b1;
        end
      end
    end
  end

  assign rx_byte       = obyte_q;
  assign rx_byte_valid = ovalid_q;
  assign rx_overrun    = ovr_q;
  assign rx_synced     = synced_q;
  assign sync_lost     = lost_q;

  wire cts_ok = !ext_mode || cts || (cts_pulse && cts_lat_q);
  wire tx_go  = tx_en && cts_ok && (!tx_follow_rx || synced_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cts_lat_q <= 1'b0;
    else if (!tx_en) cts_lat_q <= 1'b0;
    else if (cts)    cts_lat_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh_q    <= '0;
      tcnt_q   <= '0;
      tbit_q   <= 1'b0;
      tvalid_q <= 1'b0;
    end else begin
      tvalid_q <= 1'b0;
      if (!tx_go) begin
        tcnt_q <= '0;
      end else if (tcnt_q == '0) begin
        if (tx_byte_valid) begin
          tsh_q  <= tx_byte;
          tcnt_q <= BC_W'(BYTE_W);
        end
      end else if (tx_tick) begin
        tbit_q   <= tsh_q[BYTE_W-1];
        tvalid_q <= 1'b1;
        tsh_q    <= tsh_q << 1;
        tcnt_q   <= tcnt_q - 1'b1;
      end
    end
  end

  assign tx_byte_ready = tx_go && (tcnt_q == '0);
  assign tx_bit        = tbit_q;
  assign tx_bit_valid  = tvalid_q;

  a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_valid && !rx_byte_ready) |=> (!rx_en || (rx_byte_valid && $stable(rx_byte))));

  a_r4_lost_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> ($past(rx_synced) && !rx_synced));

  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_synced);

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_byte_valid && !rx_byte_ready));

  a_r10_bit_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_valid |-> $past(tx_go));
endmodule

// File: tb/serial_sync_gate_tb_top.sv
module serial_sync_gate_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rx_en, cd_pulse, cd, rx_bit_valid, rx_bit, rx_byte_ready;
  logic tx_en, tx_follow_rx, cts_pulse, cts, tx_byte_valid, tx_tick;
  logic [1:0] sync_len;
  logic [15:0] sync_pat;
  logic [7:0] tx_byte, rx_byte;
  logic rx_byte_valid, rx_overrun, rx_synced, sync_lost, tx_byte_ready, tx_bit, tx_bit_valid;

  serial_sync_gate dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_len(sync_len), .sync_pat(sync_pat),
    .cd_pulse(cd_pulse), .cd(cd), .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit),
    .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_byte_ready(rx_byte_ready),
    .rx_overrun(rx_overrun), .rx_synced(rx_synced), .sync_lost(sync_lost),
    .tx_en(tx_en), .tx_follow_rx(tx_follow_rx), .cts_pulse(cts_pulse), .cts(cts),
    .tx_byte(tx_byte), .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tx_byte_ready),
    .tx_tick(tx_tick), .tx_bit(tx_bit), .tx_bit_valid(tx_bit_valid));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rx_q[$];
  logic       tx_q[$];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_bits(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      rx_bit_valid = 1'b1;
      rx_bit = v[i];
      step();
    end
    rx_bit_valid = 1'b0;
    step();
  endtask

  task automatic send_rx_byte(logic [7:0] b, bit expect_it);
    if (expect_it) rx_q.push_back(b);
    send_bits({8'h00, b}, 8);
  endtask

  task automatic send_tx_byte(logic [7:0] b);
    while (!tx_byte_ready) step();
    tx_byte = b;
    tx_byte_valid = 1'b1;
    for (int i = 7; i >= 0; i--) tx_q.push_back(b[i]);
    step();
    tx_byte_valid = 1'b0;
    step(12);
  endtask

  task automatic config_rx(logic [1:0] len, logic [15:0] pat);
    rx_en = 1'b0;
    sync_len = len;
    sync_pat = pat;
    step();
    rx_en = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_byte_valid && rx_byte_ready) begin
      if (rx_q.size() == 0) check("R6 unexpected rx byte", {8'h00, rx_byte}, 16'hFFFF);
      else check("R6 rx byte", {8'h00, rx_byte}, {8'h00, rx_q.pop_front()});
    end
    if (rst_n && tx_bit_valid) begin
      if (tx_q.size() == 0) check("R10 unexpected tx bit", {15'h0, tx_bit}, 16'hFFFF);
      else check("R10 tx bit", {15'h0, tx_bit}, {15'h0, tx_q.pop_front()});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_en = 0; sync_len = 2'b01; sync_pat = 16'h0; cd_pulse = 0; cd = 0;
    rx_bit_valid = 0; rx_bit = 0; rx_byte_ready = 1; tx_en = 0; tx_follow_rx = 0;
    cts_pulse = 0; cts = 0; tx_byte = 0; tx_byte_valid = 0; tx_tick = 1;
    step(3);
    check("reset rx_synced", {15'h0, rx_synced}, 16'h0);
    check("reset rx_byte_valid", {15'h0, rx_byte_valid}, 16'h0);
    check("reset tx_byte_ready", {15'h0, tx_byte_ready}, 16'h0);
    rst_n = 1;
    step();

    // R1 R2: 4-bit pattern, low nibble of 0x123A -> line order 1,0,1,0
    config_rx(2'b01, 16'h123A);
    send_bits(16'b000101, 6);
    check("R2 not synced before last pattern bit", {15'h0, rx_synced}, 16'h0);
    send_bits(16'b0, 1);
    check("R1 4-bit pattern sync", {15'h0, rx_synced}, 16'h1);
    send_rx_byte(8'hC3, 1);
    send_rx_byte(8'h5A, 1);

    // R5: capture only while disabled; 8-bit pattern 0x7E
    config_rx(2'b10, 16'h007E);
    sync_pat = 16'h0081;
    sync_len = 2'b11;
    send_bits(16'h007E, 8);
    check("R5 config changed while enabled ignored", {15'h0, rx_synced}, 16'h1);
    send_rx_byte(8'h3C, 1);
    rx_en = 0;
    step();
    check("R5 disable clears sync", {15'h0, rx_synced}, 16'h0);

    // R2: 16-bit pattern, 15 bits never match
    config_rx(2'b11, 16'hB00F);
    send_bits(16'h5807, 15);
    check("R2 15 of 16 bits no sync", {15'h0, rx_synced}, 16'h0);
    send_bits(16'h1, 1);
    check("R1 16-bit pattern sync", {15'h0, rx_synced}, 16'h1);
    send_rx_byte(8'h96, 1);
    config_rx(2'b11, 16'hB00F);
    send_bits(16'hB00E, 16);
    check("R1 near-miss pattern no sync", {15'h0, rx_synced}, 16'h0);

    // R3: external pulse mode
    cd_pulse = 1;
    config_rx(2'b00, 16'h0);
    step(2);
    check("R3 no sync without cd", {15'h0, rx_synced}, 16'h0);
    cd = 1; step(); cd = 0; step();
    check("R3 pulse latches sync", {15'h0, rx_synced}, 16'h1);
    send_rx_byte(8'hA5, 1);

    // R4: external level mode, carrier drop mid-byte
    cd_pulse = 0;
    config_rx(2'b00, 16'h0);
    cd = 1; step();
    check("R4 level sync", {15'h0, rx_synced}, 16'h1);
    send_bits(16'b101, 3);
    cd = 0; step();
    check("R4 sync_lost pulse", {15'h0, sync_lost}, 16'h1);
    check("R4 sync cleared", {15'h0, rx_synced}, 16'h0);
    step();
    check("R4 sync_lost one cycle", {15'h0, sync_lost}, 16'h0);
    cd = 1; step();
    send_rx_byte(8'hE1, 1);

    // R7: overrun keeps first byte
    rx_byte_ready = 0;
    send_rx_byte(8'h11, 1);
    send_rx_byte(8'h22, 0);
    check("R7 overrun set", {15'h0, rx_overrun}, 16'h1);
    check("R7 first byte held", {8'h0, rx_byte}, 16'h0011);
    rx_byte_ready = 1;
    step(2);
    check("R7 overrun sticky", {15'h0, rx_overrun}, 16'h1);
    rx_en = 0; cd = 0; step();
    check("R7 overrun cleared by disable", {15'h0, rx_overrun}, 16'h0);

    // R11: pattern mode ignores cts
    config_rx(2'b01, 16'h000A);
    rx_en = 0;
    tx_en = 1; cts = 0; step();
    check("R11 pattern mode tx ready with cts low", {15'h0, tx_byte_ready}, 16'h1);
    send_tx_byte(8'h96);

    // R9: slaved to receiver
    tx_follow_rx = 1; step();
    check("R9 tx held until rx sync", {15'h0, tx_byte_ready}, 16'h0);
    rx_en = 1;
    send_bits(16'b1010, 4);
    check("R9 tx released by rx sync", {15'h0, tx_byte_ready}, 16'h1);
    send_tx_byte(8'h5C);
    tx_follow_rx = 0;

    // R8: level cts, drop discards held byte
    config_rx(2'b00, 16'h0);
    rx_en = 0; cts_pulse = 0; cts = 0; step();
    check("R8 level cts low holds tx", {15'h0, tx_byte_ready}, 16'h0);
    cts = 1; step();
    check("R8 level cts high releases tx", {15'h0, tx_byte_ready}, 16'h1);
    send_tx_byte(8'hF0);
    tx_tick = 0;
    tx_byte = 8'h81; tx_byte_valid = 1; step(); tx_byte_valid = 0;
    cts = 0; step(); tx_tick = 1; step(10);
    cts = 1; step();
    check("R8 cts drop discarded byte", {15'h0, tx_byte_ready}, 16'h1);

    // R8: pulse cts
    cts_pulse = 1; cts = 0; tx_en = 0; step();
    tx_en = 1; step();
    check("R8 pulse mode waits for cts", {15'h0, tx_byte_ready}, 16'h0);
    cts = 1; step(); cts = 0; step();
    check("R8 cts pulse latched", {15'h0, tx_byte_ready}, 16'h1);
    send_tx_byte(8'h3A);

    step(4);
    check("R6 all rx bytes delivered", 16'(rx_q.size()), 16'h0);
    check("R10 all tx bits sent", 16'(tx_q.size()), 16'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule